// File: doc/BRIEF.md
# Serial Multiplexed ADC Frame Master

This block runs one conversion on an external 8-bit successive-approximation converter that has an analog input multiplexer behind a three-wire serial link. A caller hands over a channel number and a flag that picks single-ended or differential input. The block builds the multiplexer address word for the configured multiplexer width. It then runs one 16-clock serial frame with an active-low chip select, a serial clock and a data-out line, samples the converter's data line, and returns an unsigned 8-bit result.

The parameter `MUX_BITS` (0 to 3) sets the size of the multiplexer: 1, 2, 4 or 8 analog inputs. With `MUX_BITS` of 0 the converter has a single fixed input. No address is sent in that case, and the result sits at a fixed offset inside the received word. The serial clock runs at the system clock divided by `2*CLK_DIV`.

Request side rules: a request is taken on a rising `clk` edge where `req_valid` and `req_ready` are both high. `req_chan` and `req_diff` are sampled only on that edge. `req_ready` stays low from acceptance through the frame and the idle gap after it, and a request presented while it is low is neither taken nor queued. The result side has no back-pressure. `res_valid` is a single-cycle pulse, and `res_data` holds its value until the next result.

Top module: `adc_frame_master`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, `req_ready` is high, `busy` is low and `res_valid` is low.
- R2: Each accepted request produces exactly one frame, with exactly 16 rising `sclk` edges while `cs_n` is low. `sclk` is low whenever `cs_n` is high.
- R3: For `MUX_BITS` of 1 to 3, the first 8 bits sampled on rising `sclk` are the address byte, sent MSB first. The address byte is built as follows: start bit 1 at bit `MUX_BITS+2`; SGL at bit `MUX_BITS+1`, which is 1 for single-ended and 0 for differential; ODD at bit `MUX_BITS`, equal to `req_chan[0]`; the select value `req_chan>>1` in bits `MUX_BITS-1..1`; bit 0 is 0. For `MUX_BITS`=3 the byte is 0,0,1,SGL,ODD,chan[2],chan[1],0. The last 8 bits sent are 0.
- R4: For `MUX_BITS` of 1 to 3, `res_data` equals received bits 9 to 16 of the frame, taken MSB first. Received bit k is the `din` value on the k-th rising `sclk` edge.
- R5: For `MUX_BITS`=0, `dout` stays 0 for the whole frame. `res_data` is bits [13:6] of the 16-bit received word, where the first received bit is bit 15.
- R6: `cs_n` falls `CLK_DIV` system clocks before the first rising `sclk` edge. Each `sclk` level lasts `CLK_DIV` system clocks. `dout` changes only while `sclk` is low.
- R7: `busy` is high and `req_ready` is low from acceptance until the frame has ended. A request made while busy starts no frame and does not change the result.
- R8: `res_valid` is a one-cycle pulse on the cycle in which `cs_n` returns high. `res_data` holds its value afterwards.
- R9: Between the rise of `cs_n` and its next fall, `cs_n` stays high for at least `2*CLK_DIV` system clocks, even when requests are back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request valid |
| req_ready | output | 1 | Block can take a request |
| req_chan | input | max(1,MUX_BITS) | Channel number, or differential pair and polarity |
| req_diff | input | 1 | 1 selects a differential conversion |
| res_valid | output | 1 | One-cycle result pulse |
| res_data | output | 8 | Unsigned conversion result |
| busy | output | 1 | Conversion in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| dout | output | 1 | Serial address data to the converter |
| din | input | 1 | Serial conversion data from the converter |

## Verification
Two cases are hard to reach from the ports. The first is the minimum idle gap between frames, which only shows when a second request is ready at the earliest moment the block can take it. The bench reaches it by holding `req_valid` high across a result, so the next frame starts as soon as `req_ready` returns, and then measures how long `cs_n` stays high. The second is a request that arrives mid-frame. The bench pulses `req_valid` with a different channel while the frame is running, then confirms that only one frame ran and that the returned address and data belong to the first request.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int FRAME_LEN = 16;
  localparam int RES_W     = 8;
  localparam int ADDR_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP
  } frame_state_e;
endpackage

// File: rtl/adc_half_tick.sv
module adc_half_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_addr_encoder.sv
module adc_addr_encoder
  import adc_frame_pkg::*;
#(
  parameter int MUX_BITS = 3,
  localparam int CHAN_W = (MUX_BITS == 0) ? 1 : MUX_BITS
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic              diff,
  output logic [ADDR_W-1:0] addr_byte
);
  generate
    if (MUX_BITS == 0) begin : g_none
      logic unused_in;
      assign unused_in = ^{chan, diff};
      assign addr_byte = '0;
    end else begin : g_addr
      logic [ADDR_W-1:0] word;
      always_comb begin
        word = ADDR_W'(1) << (MUX_BITS + 1);
        if (!diff) word = word | (ADDR_W'(1) << MUX_BITS);
        word = word | (ADDR_W'(chan[0]) << (MUX_BITS - 1));
        if (MUX_BITS > 1) word = word | ADDR_W'(chan >> 1);
      end
      // extra left shift lines the result MSB up with frame bit 9
      assign addr_byte = word << 1;
    end
  endgenerate
endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture
  import adc_frame_pkg::*;
#(
  parameter int MUX_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             din,
  output logic [RES_W-1:0] result
);
  logic [FRAME_LEN-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (clear)    sh <= '0;
    else if (shift_en) sh <= {sh[FRAME_LEN-2:0], din};
  end

  generate
    if (MUX_BITS == 0) begin : g_fixed
      // skip the tri-state bit and the leading zero
      assign result = sh[FRAME_LEN-3 -: RES_W];
    end else begin : g_addr
      assign result = sh[RES_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
  import adc_frame_pkg::*;
#(
  parameter int MUX_BITS = 3,
  parameter int CLK_DIV  = 4,
  localparam int CHAN_W = (MUX_BITS == 0) ? 1 : MUX_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              req_diff,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              dout,
  input  logic              din
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_LEN - 1);

  frame_state_e         state;
  logic                 tick;
  logic                 accept;
  logic                 sample_en;
  logic                 gap_half;
  logic [IDX_W-1:0]     bit_idx;
  logic [FRAME_LEN-1:0] tx_sh;
  logic [ADDR_W-1:0]    addr_byte;
  logic [RES_W-1:0]     rx_result;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign sample_en = (state == ST_LOW) && tick;
  assign dout      = tx_sh[FRAME_LEN-1];

  adc_half_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  adc_addr_encoder #(.MUX_BITS(MUX_BITS)) u_enc (
    .chan     (req_chan),
    .diff     (req_diff),
    .addr_byte(addr_byte)
  );

  adc_rx_capture #(.MUX_BITS(MUX_BITS)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .shift_en(sample_en),
    .din     (din),
    .result  (rx_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      tx_sh     <= '0;
      bit_idx   <= '0;
      gap_half  <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cs_n    <= 1'b0;
            tx_sh   <= {addr_byte, {(FRAME_LEN-ADDR_W){1'b0}}};
            bit_idx <= '0;
            state   <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (bit_idx == LAST_BIT) begin
              state <= ST_TAIL;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              tx_sh   <= tx_sh << 1;
              state   <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n      <= 1'b1;
            tx_sh     <= '0;
            res_valid <= 1'b1;
            res_data  <= rx_result;
            gap_half  <= 1'b0;
            state     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) state <= ST_IDLE;
            else          gap_half <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_master_chk.sv
module adc_frame_master_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic dout,
  input logic req_ready,
  input logic res_valid,
  input logic busy
);
  localparam int GAP = 2 * CLK_DIV;
  localparam int GW  = $clog2(GAP + 2);

  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_cnt <= GW'(GAP);
    else if (!cs_n)                    gap_cnt <= '0;
    else if (gap_cnt < GW'(GAP))       gap_cnt <= gap_cnt + 1'b1;
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_dout_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && (dout != $past(dout))) |-> !sclk);

  assert_busy_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (busy && !req_ready));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_done_with_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(cs_n));

  assert_idle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (gap_cnt >= GW'(GAP)));
endmodule

bind adc_frame_master adc_frame_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .dout     (dout),
  .req_ready(req_ready),
  .res_valid(res_valid),
  .busy     (busy)
);

// File: tb/tb_adc_frame_master.sv
module tb_adc_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  // three-bit multiplexer instance
  logic       v3 = 0, d3 = 0, rdy3, rv3, bsy3, cs3, sck3, do3;
  logic       di3 = 0;
  logic [2:0] c3 = '0;
  logic [7:0] rd3;
  // no-address instance
  logic       v0 = 0, d0 = 0, rdy0, rv0, bsy0, cs0, sck0, do0;
  logic       di0 = 0;
  logic [0:0] c0 = '0;
  logic [7:0] rd0;

  adc_frame_master #(.MUX_BITS(3), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(v3), .req_ready(rdy3),
    .req_chan(c3), .req_diff(d3), .res_valid(rv3), .res_data(rd3),
    .busy(bsy3), .cs_n(cs3), .sclk(sck3), .dout(do3), .din(di3));

  adc_frame_master #(.MUX_BITS(0), .CLK_DIV(DIV)) dut_m0 (
    .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_ready(rdy0),
    .req_chan(c0), .req_diff(d0), .res_valid(rv0), .res_data(rd0),
    .busy(bsy0), .cs_n(cs0), .sclk(sck0), .dout(do0), .din(di0));

  // converter models and monitors
  logic [15:0] pat3 = '0, pat0 = '0, tx3 = '0, tx0 = '0;
  int idx3 = 0, idx0 = 0, rise3 = 0, rise0 = 0, frames3 = 0, pulses3 = 0;
  time t_fall3 = 0, t_rise3 = 0, t_first3 = 0, t_ff3 = 0;

  always @(negedge cs3) begin
    idx3 = 0; di3 = pat3[15]; rise3 = 0; tx3 = '0;
    frames3++; t_fall3 = $time;
  end
  always @(posedge cs3) t_rise3 = $time;
  always @(negedge sck3) if (!cs3) begin
    if (idx3 == 0) t_ff3 = $time;
    idx3++;
    if (idx3 < 16) di3 = pat3[15-idx3];
  end
  always @(posedge sck3) begin
    tx3 = {tx3[14:0], do3}; rise3++;
    if (rise3 == 1) t_first3 = $time;
  end
  always @(negedge clk) if (rv3) pulses3++;

  always @(negedge cs0) begin idx0 = 0; di0 = pat0[15]; rise0 = 0; tx0 = '0; end
  always @(negedge sck0) if (!cs0) begin
    idx0++;
    if (idx0 < 16) di0 = pat0[15-idx0];
  end
  always @(posedge sck0) begin tx0 = {tx0[14:0], do0}; rise0++; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wait_rv3();
    int n = 0;
    do begin @(negedge clk); n++; end while (!rv3 && n < 2000);
    chk(rv3, "R8 done seen", int'(rv3), 1);
  endtask

  task automatic wait_idle3();
    int n = 0;
    while (!rdy3 && n < 2000) begin @(negedge clk); n++; end
  endtask

  function automatic logic [7:0] addr3(input logic [2:0] ch, input bit diff);
    return {2'b00, 1'b1, ~diff, ch[0], ch[2:1], 1'b0};
  endfunction

  task automatic t_reset();
    chk(cs3 == 1'b1, "R1 cs_n", int'(cs3), 1);
    chk(sck3 == 1'b0, "R1 sclk", int'(sck3), 0);
    chk(rdy3 == 1'b1, "R1 req_ready", int'(rdy3), 1);
    chk(bsy3 == 1'b0, "R1 busy", int'(bsy3), 0);
    chk(rv3 == 1'b0, "R1 res_valid", int'(rv3), 0);
  endtask

  task automatic t_conv3(input logic [2:0] ch, input bit diff, input logic [15:0] pat,
                         input bit check_timing);
    int f0;
    logic [7:0] held;
    pat3 = pat; pulses3 = 0; f0 = frames3;
    @(negedge clk); c3 = ch; d3 = diff; v3 = 1'b1;
    @(negedge clk); v3 = 1'b0; c3 = ~ch;
    wait_rv3();
    chk(rd3 == pat[7:0], "R4 result", int'(rd3), int'(pat[7:0]));
    chk(rise3 == 16, "R2 sclk rises", rise3, 16);
    chk(frames3 == f0 + 1, "R2 one frame", frames3 - f0, 1);
    chk(tx3[15:8] == addr3(ch, diff), "R3 address", int'(tx3[15:8]), int'(addr3(ch, diff)));
    chk(tx3[7:0] == 8'h00, "R3 trailing zeros", int'(tx3[7:0]), 0);
    chk(cs3 == 1'b1, "R8 cs_n high at done", int'(cs3), 1);
    held = rd3;
    repeat (3) @(negedge clk);
    chk(pulses3 == 1, "R8 single pulse", pulses3, 1);
    chk(rd3 == held, "R8 result held", int'(rd3), int'(held));
    if (check_timing) begin
      chk(t_first3 - t_fall3 == DIV*CLK_PERIOD, "R6 cs lead", int'(t_first3 - t_fall3), DIV*CLK_PERIOD);
      chk(t_ff3 - t_first3 == DIV*CLK_PERIOD, "R6 sclk high time", int'(t_ff3 - t_first3), DIV*CLK_PERIOD);
    end
    wait_idle3();
  endtask

  task automatic t_busy_ignored_R7();
    int f0;
    pat3 = 16'h1E_6B; f0 = frames3;
    @(negedge clk); c3 = 3'd2; d3 = 1'b0; v3 = 1'b1;
    @(negedge clk); v3 = 1'b0;
    repeat (12) @(negedge clk);
    chk(rdy3 == 1'b0 && bsy3 == 1'b1, "R7 busy mid-frame", int'({bsy3, rdy3}), 2);
    c3 = 3'd7; d3 = 1'b1; v3 = 1'b1;
    @(negedge clk); v3 = 1'b0;
    wait_rv3();
    chk(rd3 == 8'h6B, "R7 result from first request", int'(rd3), 8'h6B);
    chk(tx3[15:8] == addr3(3'd2, 1'b0), "R7 address from first request",
        int'(tx3[15:8]), int'(addr3(3'd2, 1'b0)));
    repeat (6*DIV + 4) @(negedge clk);
    chk(frames3 == f0 + 1, "R7 no extra frame", frames3 - f0, 1);
  endtask

  task automatic t_back_to_back_R9();
    int n;
    pat3 = 16'h00_C3;
    @(negedge clk); c3 = 3'd4; d3 = 1'b0; v3 = 1'b1;
    wait_rv3();
    pat3 = 16'h00_5A;
    n = 0;
    while (cs3 && n < 1000) begin @(negedge clk); n++; end
    v3 = 1'b0;
    chk(t_fall3 - t_rise3 >= 2*DIV*CLK_PERIOD, "R9 idle gap",
        int'(t_fall3 - t_rise3), 2*DIV*CLK_PERIOD);
    wait_rv3();
    chk(rd3 == 8'h5A, "R9 second result", int'(rd3), 8'h5A);
    wait_idle3();
  endtask

  task automatic t_conv0_R5(input logic [15:0] pat);
    int n = 0;
    pat0 = pat;
    @(negedge clk); c0 = 1'b1; d0 = 1'b1; v0 = 1'b1;
    @(negedge clk); v0 = 1'b0;
    do begin @(negedge clk); n++; end while (!rv0 && n < 2000);
    chk(rd0 == pat[13:6], "R5 result bits 13:6", int'(rd0), int'(pat[13:6]));
    chk(tx0 == 16'h0000, "R5 dout held low", int'(tx0), 0);
    chk(rise0 == 16, "R5 sclk rises", rise0, 16);
    n = 0;
    while (!rdy0 && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_conv3(3'd0, 1'b1, 16'h00_A5, 1'b1);
    t_conv3(3'd5, 1'b0, 16'hFF_00, 1'b0);
    t_conv3(3'd7, 1'b1, 16'h00_FF, 1'b0);
    t_conv3(3'd2, 1'b0, 16'h3C_3C, 1'b0);
    t_busy_ignored_R7();
    t_back_to_back_R9();
    t_conv0_R5(16'b0010_1100_1101_0111);
    t_conv0_R5(16'b1011_1111_1100_0000);
    finish_run();
  end
endmodule